// File: doc/BRIEF.md
# Serial Synthesizer Control Port

This block is the programming front end of a frequency synthesizer. A host writes control words over three serial pins (a shift clock, a data line and a word strobe) plus a fourth strobe for an auxiliary control byte. All pins are brought into the system clock domain and their edges are detected there, so the serial clock may be any rate well below the system clock.

A 21-bit word is shifted in with its first bit as the most significant. The last bit shifted is a destination select. When the word strobe rises, the word is copied into one of two holding registers. One holds the divider settings: reference divide, main divide, swallow count and prescaler bypass. The other holds the 18-bit fractional word. A separate 8-bit control byte is shifted while the auxiliary strobe is high and is latched when that strobe falls. It reaches the outputs only while an active-low enable pin is held low.

A bypass input lets the divider settings come straight from parallel pins instead of from the serial holding register. All outputs are registered.

Top module: `serprog_port`

## Requirements
- R1: While reset is high, every output is zero on the next clock, and all holding registers are cleared.
- R2: With both strobes low, each rising edge of the serial clock shifts the data bit into a 21-bit shift register, first bit most significant. The last bit shifted is the destination select.
- R3: On a word strobe rising edge with select 0, the divider fields are decoded from the first 20 bits in arrival order: rdiv bit5, rdiv bit4, mdiv bit8, mdiv bit7, prescaler bypass, mdiv bits 6 to 0, rdiv bits 3 to 0, then swallow bits 3 to 0.
- R4: On a word strobe rising edge with select 1, the first 18 bits become the fractional word, most significant first. The next two bits are ignored, and the divider fields keep their values.
- R5: Shifting alone changes no output. Holding registers update only on a word strobe rising edge.
- R6: With the auxiliary strobe high and the word strobe low, serial clock edges shift an 8-bit control byte, first bit most significant. The byte is latched on the auxiliary strobe falling edge. These edges leave the 21-bit word untouched.
- R7: The control byte drives ctl_o only while aux_en_n_i is low, and ctl_o is zero while it is high. ctl_o bits: 7 lock-detect off, 6 route reference tick to test pin, 5 route modulus select to test pin, 4 immediate counter load, 3 power down, 2 route main tick to test pin, 1 and 0 reserved.
- R8: While bypass_i is high, the divider outputs follow the parallel pins, and serial loads do not affect them. The fractional word still loads serially.
- R9: If more than 21 bits are shifted before the strobe, the last 21 bits shifted form the transferred word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_dat_i | input | 1 | Serial data |
| word_ld_i | input | 1 | Word strobe, transfer on rising edge |
| aux_ld_i | input | 1 | Control-byte strobe, shift while high, latch on falling edge |
| aux_en_n_i | input | 1 | Active-low enable for the control byte |
| bypass_i | input | 1 | Take the divider fields from the parallel pins |
| par_rdiv_i | input | 6 | Parallel reference divide |
| par_mdiv_i | input | 9 | Parallel main divide |
| par_aswal_i | input | 4 | Parallel swallow count |
| par_presc_off_i | input | 1 | Parallel prescaler bypass |
| rdiv_o | output | 6 | Reference divide setting |
| mdiv_o | output | 9 | Main divide setting |
| aswal_o | output | 4 | Swallow count setting |
| presc_off_o | output | 1 | Prescaler bypass setting |
| kfrac_o | output | 18 | Fractional word |
| ctl_o | output | 8 | Gated control byte |

## Verification
Divider words use distinct asymmetric field values, so a swapped or shifted bit lands in a visibly wrong field. A fractional word sent with its ignored bits set shows whether the select bit routes correctly and whether the reserved bits leak. A word shifted without a strobe, a control byte shifted without a falling strobe, and an over-long word with leading junk separate the shift from the transfer. Bypass runs with a serial load in between show that the parallel pins take priority only for the divider fields.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  localparam int R_W    = 6;
  localparam int M_W    = 9;
  localparam int A_W    = 4;
  localparam int K_W    = 18;
  localparam int CTL_W  = 8;
  localparam int RSV_W  = 2;
  localparam int WORD_W = R_W + M_W + A_W + 1 + 1;  // fields, bypass bit, select

  typedef struct packed {
    logic [R_W-1:0] rdiv;
    logic [M_W-1:0] mdiv;
    logic [A_W-1:0] aswal;
    logic           presc_off;
  } cnt_t;

  // bit 0 of the shift register is the last bit shifted (select)
  function automatic cnt_t unpack_cnt(input logic [WORD_W-1:0] w);
    cnt_t c;
    c.rdiv      = {w[20], w[19], w[8:5]};
    c.mdiv      = {w[18], w[17], w[15:9]};
    c.presc_off = w[16];
    c.aswal     = w[4:1];
    return c;
  endfunction
endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int TOT = WIDTH * STAGES;
  logic [TOT-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[TOT-WIDTH-1:0], d};
      end
    end
  endgenerate

  assign q = chain[TOT-1 -: WIDTH];
endmodule

// File: rtl/serprog_shift.sv
module serprog_shift
  import serprog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              main_shift,
  input  logic              aux_shift,
  input  logic              din,
  output logic [WORD_W-1:0] main_q,
  output logic [CTL_W-1:0]  aux_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      main_q <= '0;
      aux_q  <= '0;
    end else begin
      if (main_shift) main_q <= {main_q[WORD_W-2:0], din};
      if (aux_shift)  aux_q  <= {aux_q[CTL_W-2:0], din};
    end
  end
endmodule

// File: rtl/serprog_regs.sv
module serprog_regs
  import serprog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_cap,
  input  logic              aux_cap,
  input  logic [WORD_W-1:0] main_q,
  input  logic [CTL_W-1:0]  aux_q,
  input  logic              bypass,
  input  logic              aux_en_n,
  input  cnt_t              par_cnt,
  output cnt_t              cnt_o,
  output logic [K_W-1:0]    k_o,
  output logic [CTL_W-1:0]  ctl_o
);
  localparam int K_LSB = WORD_W - K_W;

  cnt_t             hold_cnt;
  logic [K_W-1:0]   hold_k;
  logic [CTL_W-1:0] hold_ctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      hold_k   <= '0;
      hold_ctl <= '0;
    end else begin
      if (word_cap) begin
        if (main_q[0]) hold_k   <= main_q[WORD_W-1:K_LSB];
        else           hold_cnt <= unpack_cnt(main_q);
      end
      if (aux_cap) hold_ctl <= aux_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
      k_o   <= '0;
      ctl_o <= '0;
    end else begin
      cnt_o <= bypass ? par_cnt : hold_cnt;
      k_o   <= hold_k;
      ctl_o <= aux_en_n ? '0 : hold_ctl;
    end
  end
endmodule

// File: rtl/serprog_port.sv
module serprog_port
  import serprog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             word_ld_i,
  input  logic             aux_ld_i,
  input  logic             aux_en_n_i,
  input  logic             bypass_i,
  input  logic [R_W-1:0]   par_rdiv_i,
  input  logic [M_W-1:0]   par_mdiv_i,
  input  logic [A_W-1:0]   par_aswal_i,
  input  logic             par_presc_off_i,
  output logic [R_W-1:0]   rdiv_o,
  output logic [M_W-1:0]   mdiv_o,
  output logic [A_W-1:0]   aswal_o,
  output logic             presc_off_o,
  output logic [K_W-1:0]   kfrac_o,
  output logic [CTL_W-1:0] ctl_o
);
  logic [3:0] pins_s;
  logic       s_clk, s_dat, s_wld, s_ald;
  logic       p_clk, p_wld, p_ald;
  logic       main_shift, aux_shift, word_cap, aux_cap;
  logic [WORD_W-1:0] main_q;
  logic [CTL_W-1:0]  aux_q;
  cnt_t par_cnt, cnt_q;

  serprog_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({ser_clk_i, ser_dat_i, word_ld_i, aux_ld_i}),
    .q(pins_s)
  );
  assign {s_clk, s_dat, s_wld, s_ald} = pins_s;

  always_ff @(posedge clk) begin
    if (rst) {p_clk, p_wld, p_ald} <= '0;
    else     {p_clk, p_wld, p_ald} <= {s_clk, s_wld, s_ald};
  end

  assign main_shift = s_clk & ~p_clk & ~s_wld & ~s_ald;
  assign aux_shift  = s_clk & ~p_clk & ~s_wld &  s_ald;
  assign word_cap   = s_wld & ~p_wld;
  assign aux_cap    = ~s_ald & p_ald;

  serprog_shift u_shift (
    .clk(clk), .rst(rst), .main_shift(main_shift), .aux_shift(aux_shift),
    .din(s_dat), .main_q(main_q), .aux_q(aux_q)
  );

  assign par_cnt = '{rdiv: par_rdiv_i, mdiv: par_mdiv_i,
                     aswal: par_aswal_i, presc_off: par_presc_off_i};

  serprog_regs u_regs (
    .clk(clk), .rst(rst), .word_cap(word_cap), .aux_cap(aux_cap),
    .main_q(main_q), .aux_q(aux_q), .bypass(bypass_i), .aux_en_n(aux_en_n_i),
    .par_cnt(par_cnt), .cnt_o(cnt_q), .k_o(kfrac_o), .ctl_o(ctl_o)
  );

  assign rdiv_o      = cnt_q.rdiv;
  assign mdiv_o      = cnt_q.mdiv;
  assign aswal_o     = cnt_q.aswal;
  assign presc_off_o = cnt_q.presc_off;
endmodule

// File: rtl/serprog_port_chk.sv
module serprog_port_chk
  import serprog_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             aux_en_n_i,
  input logic             bypass_i,
  input logic [R_W-1:0]   par_rdiv_i,
  input logic [R_W-1:0]   rdiv_o,
  input logic [K_W-1:0]   kfrac_o,
  input logic [CTL_W-1:0] ctl_o,
  input logic             word_cap
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (kfrac_o == '0 && ctl_o == '0 && rdiv_o == '0));

  a_r7_gate_blocks: assert property (@(posedge clk) disable iff (rst)
    aux_en_n_i |=> (ctl_o == '0));

  a_r8_bypass_follows: assert property (@(posedge clk) disable iff (rst)
    bypass_i |=> (rdiv_o == $past(par_rdiv_i)));

  a_r5_k_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !$past(word_cap, 2) |-> $stable(kfrac_o));
endmodule

bind serprog_port serprog_port_chk u_chk (
  .clk(clk), .rst(rst), .aux_en_n_i(aux_en_n_i), .bypass_i(bypass_i),
  .par_rdiv_i(par_rdiv_i), .rdiv_o(rdiv_o), .kfrac_o(kfrac_o),
  .ctl_o(ctl_o), .word_cap(word_cap)
);

// File: tb/sim_serprog_port.sv
module sim_serprog_port;
  logic clk = 0, rst = 1;
  logic ser_clk = 0, ser_dat = 0, word_ld = 0, aux_ld = 0;
  logic aux_en_n = 0, bypass = 0;
  logic [5:0]  p_r = 0;
  logic [8:0]  p_m = 0;
  logic [3:0]  p_a = 0;
  logic        p_p = 0;
  logic [5:0]  rdiv;
  logic [8:0]  mdiv;
  logic [3:0]  aswal;
  logic        presc;
  logic [17:0] kfrac;
  logic [7:0]  ctl;
  int total = 0, bad = 0;
  logic done = 0;

  always #10 clk = ~clk;

  serprog_port u0 (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .word_ld_i(word_ld), .aux_ld_i(aux_ld), .aux_en_n_i(aux_en_n),
    .bypass_i(bypass), .par_rdiv_i(p_r), .par_mdiv_i(p_m),
    .par_aswal_i(p_a), .par_presc_off_i(p_p), .rdiv_o(rdiv), .mdiv_o(mdiv),
    .aswal_o(aswal), .presc_off_o(presc), .kfrac_o(kfrac), .ctl_o(ctl)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_dat = b; tick(3);
    ser_clk = 1; tick(3);
    ser_clk = 0; tick(2);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic strobe_word;
    word_ld = 1; tick(6);
    word_ld = 0; tick(8);
  endtask

  // R3 arrival order, select bit 0 last
  function automatic logic [20:0] cword(input logic [5:0] r, input logic [8:0] m,
                                        input logic [3:0] a, input logic p);
    return {r[5], r[4], m[8], m[7], p, m[6:0], r[3:0], a, 1'b0};
  endfunction

  function automatic logic [20:0] kword(input logic [17:0] k);
    return {k, 2'b11, 1'b1};
  endfunction

  task automatic check_cnt(input string req, input logic [5:0] r, input logic [8:0] m,
                           input logic [3:0] a, input logic p);
    chk(req, rdiv, r);
    chk(req, mdiv, m);
    chk(req, aswal, a);
    chk(req, presc, p);
  endtask

  task automatic t_reset;
    check_cnt("R1 reset", 0, 0, 0, 0);
    chk("R1 reset k", kfrac, 0);
    chk("R1 reset ctl", ctl, 0);
  endtask

  task automatic t_counter;
    send(cword(6'h2D, 9'h15A, 4'hB, 1'b1), 21);
    strobe_word;
    check_cnt("R2 R3 counter word", 6'h2D, 9'h15A, 4'hB, 1'b1);
    chk("R4 k untouched by select 0", kfrac, 0);
  endtask

  task automatic t_frac;
    send(kword(18'h2A5C3), 21);
    strobe_word;
    chk("R4 fractional word", kfrac, 18'h2A5C3);
    check_cnt("R4 dividers kept", 6'h2D, 9'h15A, 4'hB, 1'b1);
  endtask

  task automatic t_hold;
    send(cword(6'h12, 9'h0C3, 4'h4, 1'b0), 21);
    tick(10);
    check_cnt("R5 no strobe no change", 6'h2D, 9'h15A, 4'hB, 1'b1);
    strobe_word;
    check_cnt("R5 strobe transfers", 6'h12, 9'h0C3, 4'h4, 1'b0);
  endtask

  task automatic t_aux;
    aux_ld = 1; tick(4);
    send(32'hA4, 8);
    tick(6);
    chk("R6 byte waits for falling strobe", ctl, 0);
    aux_ld = 0; tick(8);
    chk("R6 R7 byte latched", ctl, 8'hA4);
    strobe_word;
    check_cnt("R6 main word untouched", 6'h12, 9'h0C3, 4'h4, 1'b0);
    aux_en_n = 1; tick(4);
    chk("R7 gated off", ctl, 0);
    aux_en_n = 0; tick(4);
    chk("R7 gated back on", ctl, 8'hA4);
  endtask

  task automatic t_bypass;
    p_r = 6'h3F; p_m = 9'h101; p_a = 4'h7; p_p = 1'b1;
    bypass = 1; tick(4);
    check_cnt("R8 parallel fields", 6'h3F, 9'h101, 4'h7, 1'b1);
    send(cword(6'h05, 9'h1F0, 4'h9, 1'b0), 21);
    strobe_word;
    check_cnt("R8 serial ignored in bypass", 6'h3F, 9'h101, 4'h7, 1'b1);
    send(kword(18'h1357B), 21);
    strobe_word;
    chk("R8 k still serial", kfrac, 18'h1357B);
    bypass = 0; tick(4);
    check_cnt("R8 serial restored", 6'h05, 9'h1F0, 4'h9, 1'b0);
  endtask

  task automatic t_long;
    send(32'hB, 4);
    send(cword(6'h21, 9'h088, 4'h3, 1'b1), 21);
    strobe_word;
    check_cnt("R9 last 21 bits", 6'h21, 9'h088, 4'h3, 1'b1);
  endtask

  initial begin
    tick(5);
    t_reset;
    rst = 0; tick(4);
    t_reset;
    t_counter;
    t_frac;
    t_hold;
    t_aux;
    t_bypass;
    t_long;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule